// File: doc/BRIEF.md
# Hamming-Distance Output-Flip Lock

This block wraps a small combinational function of a W-bit input so that it gives correct results only once the right key has been programmed. A fixed stripping comparator holds a secret protected vector as an elaboration constant. It inverts every output bit whenever the input differs from that vector in exactly H bit positions. A second comparator measures the input against a programmable key and, when that distance is also exactly H, inverts the outputs again. With the key equal to the protected vector the two inversions always coincide and cancel, so the wrapper behaves like the plain function. With any other key, outputs are corrupted on inputs at distance H from exactly one of the two vectors.

The key sits in a write-once register that stands in for programmed secure storage. The register is cleared by reset and filled by the first strobe of the load port. Later strobes are ignored until the next reset. A status output shows whether a key has been taken. The stand-in function adds the lower half of the input to the upper half. W must be even. A parameter selects whether the final result is registered, which gives one cycle of latency, or left combinational.

Top module: `hd_flip_lock`

## Requirements
- R1: The stripping flip is asserted exactly when the count of set bits in (data_in XOR CUBE) equals H. A smaller nonzero distance does not assert it.
- R2: With H = 0 the stripping flip is asserted only for data_in equal to CUBE, and the restoring flip only for data_in equal to the stored key.
- R3: The restoring flip is asserted exactly when the count of set bits in (data_in XOR stored key) equals H.
- R4: Each bit of the result equals the matching bit of the function output XOR stripping flip XOR restoring flip. All result bits are inverted together.
- R5: Once the stored key equals CUBE, the result equals the unlocked function for every input value.
- R6: After reset the stored key is all zeros and key_loaded is 0.
- R7: The first cycle with key_we high stores key_wdata and sets key_loaded to 1. Later key_we strobes leave the stored key unchanged until reset.
- R8: With REG_OUT = 1, data_out shows the result for the data_in present at the previous rising clk edge and reads 0 during reset. With REG_OUT = 0, data_out follows data_in in the same cycle.
- R9: The function output is the unsigned sum of data_in[W/2-1:0] and data_in[W-1:W/2], W/2+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_we | input | 1 | Key load strobe, honoured once per reset |
| key_wdata | input | W | Key value to store |
| data_in | input | W | Input to the protected function |
| key_loaded | output | 1 | High once a key has been stored |
| data_out | output | W/2+1 | Locked function result |

## Verification
The bench targets inputs that lie one bit away from the protected vector. A design that tested "distance at most H" would also flip the vector itself. It also targets the H = 0 case, where a design built from an off-by-one count would flip a whole ring of neighbours rather than one pattern. Wrong keys, including the all-zero key left by reset, must give mismatches on exactly the union of the two disjoint distance-H shells: 16, 8 or 2 patterns per configuration. A design that corrupted any other pattern, or left some of these unflipped, fails the count. A second key write after loading, and the one-cycle registered path against the combinational one, catch a key register that does not freeze and an output stage with the wrong latency.

// File: rtl/hd_lock_pkg.sv
package hd_lock_pkg;
  // width of the protected function result for an input of w bits
  function automatic int sum_width(input int w);
    return w / 2 + 1;
  endfunction

  // width of a set-bit counter able to hold the value w
  function automatic int count_width(input int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/hd_rst_sync.sv
module hd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/hd_exact_dist.sv
module hd_exact_dist #(
  parameter int W    = 8,
  parameter int DIST = 1
) (
  input  logic [W-1:0] vec_a,
  input  logic [W-1:0] vec_b,
  output logic         hit
);
  localparam int CW = hd_lock_pkg::count_width(W);

  logic [W-1:0]  diff;
  logic [CW-1:0] ones;

  for (genvar g = 0; g < W; g++) begin : g_diff
    assign diff[g] = vec_a[g] ^ vec_b[g];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(diff[i]);
    end
  end

  assign hit = (ones == CW'(DIST));

  always_comb begin
    if (DIST == 0) begin
      AST_ZERO_DIST_SINGLE: assert (!hit || (vec_a == vec_b)); // R2
    end
  end
endmodule

// File: rtl/hd_key_store.sv
module hd_key_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] key,
  output logic         loaded
);
  logic [W-1:0] key_q, key_d;
  logic         loaded_q, loaded_d;
  logic         take;

  assign take = we && !loaded_q;

  always_comb begin
    key_d    = key_q;
    loaded_d = loaded_q;
    if (take) begin
      key_d    = wdata;
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      key_q    <= key_d;
      loaded_q <= loaded_d;
    end
  end

  assign key    = key_q;
  assign loaded = loaded_q;

  AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> $stable(key_q)); // R7
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> loaded_q); // R7
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !loaded_q) |=> (loaded_q && key_q == $past(wdata))); // R7
endmodule

// File: rtl/hd_sum_func.sv
module hd_sum_func #(
  parameter int W = 8
) (
  input  logic [W-1:0]                          x,
  output logic [hd_lock_pkg::sum_width(W)-1:0]  y
);
  localparam int HALF  = W / 2;
  localparam int OUT_W = hd_lock_pkg::sum_width(W);

  logic [OUT_W-1:0] lo_ext, hi_ext;

  assign lo_ext = {1'b0, x[HALF-1:0]};
  assign hi_ext = {1'b0, x[W-1:HALF]};
  assign y      = lo_ext + hi_ext;
endmodule

// File: rtl/hd_flip_lock.sv
module hd_flip_lock #(
  parameter int         W       = 8,
  parameter int         H       = 1,
  parameter logic [W-1:0] CUBE  = 8'hB4,
  parameter bit         REG_OUT = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  key_we,
  input  logic [W-1:0]                          key_wdata,
  input  logic [W-1:0]                          data_in,
  output logic                                  key_loaded,
  output logic [hd_lock_pkg::sum_width(W)-1:0]  data_out
);
  localparam int OUT_W = hd_lock_pkg::sum_width(W);

  logic             rst_n_s;
  logic [W-1:0]     key_val;
  logic             strip_hit, restore_hit;
  logic [OUT_W-1:0] func_y;
  logic [OUT_W-1:0] locked_y;

  hd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  hd_key_store #(.W(W)) u_key (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .we     (key_we),
    .wdata  (key_wdata),
    .key    (key_val),
    .loaded (key_loaded)
  );

  hd_sum_func #(.W(W)) u_func (
    .x (data_in),
    .y (func_y)
  );

  hd_exact_dist #(.W(W), .DIST(H)) u_strip (
    .vec_a (data_in),
    .vec_b (CUBE),
    .hit   (strip_hit)
  );

  hd_exact_dist #(.W(W), .DIST(H)) u_restore (
    .vec_a (data_in),
    .vec_b (key_val),
    .hit   (restore_hit)
  );

  assign locked_y = func_y ^ {OUT_W{strip_hit}} ^ {OUT_W{restore_hit}};

  always_comb begin
    if (key_val == CUBE) begin
      AST_FLIPS_CANCEL: assert (strip_hit == restore_hit); // R5
    end
  end

  if (REG_OUT) begin : g_out_reg
    logic [OUT_W-1:0] out_q, out_d;

    always_comb begin
      out_d = locked_y;
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) out_q <= '0;
      else          out_q <= out_d;
    end

    assign data_out = out_q;

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_s)
      $past(rst_n_s) |-> (data_out == $past(locked_y))); // R8
  end else begin : g_out_comb
    assign data_out = locked_y;
  end
endmodule

// File: tb/test_hd_flip_lock.sv
module test_hd_flip_lock;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;

  // main instance: W=8, H=1, cube B4, registered
  logic       we_m;
  logic [7:0] wd_m, d_m;
  logic       ld_m;
  logic [4:0] o_m;
  // example instance: W=4, H=1, cube 1111, registered
  logic       we_e;
  logic [3:0] wd_e, d_e;
  logic       ld_e;
  logic [2:0] o_e;
  // zero-distance instance: W=4, H=0, cube 1010, combinational
  logic       we_z;
  logic [3:0] wd_z, d_z;
  logic       ld_z;
  logic [2:0] o_z;

  hd_flip_lock #(.W(8), .H(1), .CUBE(8'hB4), .REG_OUT(1'b1)) i_hd_flip_lock (
    .clk(clk), .rst_n(rst_n), .key_we(we_m), .key_wdata(wd_m),
    .data_in(d_m), .key_loaded(ld_m), .data_out(o_m));

  hd_flip_lock #(.W(4), .H(1), .CUBE(4'hF), .REG_OUT(1'b1)) i_hd_flip_lock_ex (
    .clk(clk), .rst_n(rst_n), .key_we(we_e), .key_wdata(wd_e),
    .data_in(d_e), .key_loaded(ld_e), .data_out(o_e));

  hd_flip_lock #(.W(4), .H(0), .CUBE(4'hA), .REG_OUT(1'b0)) i_hd_flip_lock_h0 (
    .clk(clk), .rst_n(rst_n), .key_we(we_z), .key_wdata(wd_z),
    .data_in(d_z), .key_loaded(ld_z), .data_out(o_z));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int plain_func(int x, int w);
    int half_mask = (1 << (w/2)) - 1;
    return (x & half_mask) + ((x >> (w/2)) & half_mask);
  endfunction

  function automatic int locked_model(int x, int cube, int key, int w, int h);
    int  omask = (1 << (w/2 + 1)) - 1;
    bit  s     = ($countones(32'(x ^ cube)) == h);
    bit  r     = ($countones(32'(x ^ key)) == h);
    return plain_func(x, w) ^ ((s ^ r) ? omask : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R8 reset data_out main", int'(o_m), 0);
    chk("R8 reset data_out ex",   int'(o_e), 0);
    chk("R6 reset key_loaded main", int'(ld_m), 0);
    chk("R6 reset key_loaded h0",   int'(ld_z), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 key_loaded after release", int'(ld_m), 0);
  endtask

  // key still zero from reset: wrong key behaviour, 16 corrupted patterns
  task automatic t_unloaded_main();
    int miss = 0;
    for (int x = 0; x < 256; x++) begin
      d_m = 8'(x);
      @(negedge clk);
      chk("R1 R3 R4 R6 R9 unloaded key", int'(o_m), locked_model(x, 'hB4, 0, 8, 1));
      if (int'(o_m) != plain_func(x, 8)) miss++;
    end
    chk("R1 R3 mismatch count zero key", miss, 16);
  endtask

  task automatic t_load_correct_main();
    int miss = 0;
    @(negedge clk); we_m = 1'b1; wd_m = 8'hB4;
    @(negedge clk); we_m = 1'b0;
    chk("R7 key_loaded set", int'(ld_m), 1);
    for (int x = 0; x < 256; x++) begin
      d_m = 8'(x);
      @(negedge clk);
      if (int'(o_m) != plain_func(x, 8)) miss++;
    end
    chk("R5 correct key mismatches", miss, 0);
  endtask

  task automatic t_rewrite_main();
    int miss = 0;
    @(negedge clk); we_m = 1'b1; wd_m = 8'h00;
    @(negedge clk); we_m = 1'b0;
    chk("R7 key_loaded stays", int'(ld_m), 1);
    for (int x = 0; x < 256; x++) begin
      d_m = 8'(x);
      @(negedge clk);
      if (int'(o_m) != plain_func(x, 8)) miss++;
    end
    chk("R7 second write ignored", miss, 0);
  endtask

  task automatic t_latency_main();
    @(negedge clk); d_m = 8'h12;
    @(negedge clk); d_m = 8'hF0;
    #1;
    chk("R8 output holds before edge", int'(o_m), plain_func('h12, 8));
    @(negedge clk);
    chk("R8 output after one edge", int'(o_m), plain_func('hF0, 8));
  endtask

  task automatic t_example();
    int miss = 0;
    @(negedge clk); we_e = 1'b1; wd_e = 4'h0;
    @(negedge clk); we_e = 1'b0;
    d_e = 4'hE; @(negedge clk);
    chk("R1 example 1110 flips", int'(o_e), plain_func('hE, 4) ^ 7);
    d_e = 4'h7; @(negedge clk);
    chk("R1 example 0111 flips", int'(o_e), plain_func('h7, 4) ^ 7);
    d_e = 4'hF; @(negedge clk);
    chk("R1 cube itself not flipped", int'(o_e), plain_func('hF, 4));
    for (int x = 0; x < 16; x++) begin
      d_e = 4'(x);
      @(negedge clk);
      chk("R4 example model", int'(o_e), locked_model(x, 'hF, 0, 4, 1));
      if (int'(o_e) != plain_func(x, 4)) miss++;
    end
    chk("R3 example mismatch count", miss, 8);
  endtask

  task automatic t_zero_dist();
    int miss = 0;
    @(negedge clk); we_z = 1'b1; wd_z = 4'h3;
    @(negedge clk); we_z = 1'b0;
    for (int x = 0; x < 16; x++) begin
      d_z = 4'(x);
      #1;
      chk("R2 R8 zero distance comb", int'(o_z), locked_model(x, 'hA, 'h3, 4, 0));
      if (int'(o_z) != plain_func(x, 4)) miss++;
      @(negedge clk);
    end
    chk("R2 zero distance mismatch count", miss, 2);
  endtask

  initial begin
    rst_n = 1'b0;
    we_m = 0; wd_m = 0; d_m = 0;
    we_e = 0; wd_e = 0; d_e = 0;
    we_z = 0; wd_z = 0; d_z = 0;
    t_reset();
    t_unloaded_main();
    t_load_correct_main();
    t_rewrite_main();
    t_latency_main();
    t_example();
    t_zero_dist();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule